// File: doc/BRIEF.md
# CAS-before-RAS Refresh and Start-up Scheduler

This block owns all refresh traffic for a fast-page-mode DRAM array built from two ranks and four byte lanes. Coming out of reset it keeps the array untouched for a power-up pause. It then runs a short series of warm-up refresh cycles on its own. When the warm-up is over it raises `initDone`, and from then on it produces one refresh request per interval. The interval is chosen so that every row is refreshed within the retention window.

Refresh uses CAS-before-RAS ordering. Each DRAM keeps its own row counter, so no address is driven. In a refresh cycle every CAS line falls first, then both RAS lines fall together. All strobes rise together after the low time, and a precharge gap follows. WE stays high for the whole cycle.

After start-up, refresh shares the strobes with an access sequencer through a request/grant pair. `refReq` stays high while refresh work is owed. The sequencer answers with `refGrant` once the bus is free. Requests that arrive while the grant is withheld are counted, up to a limit. When the grant comes, the stored requests are drained back to back. A request that arrives when the count is already full sets a sticky `overflow` flag.

All timings are set in nanoseconds and converted to clock counts from the clock frequency parameter. A speed-grade parameter chooses between the 50 ns and 60 ns values.

Top module: `cbr_refresh_sched`

## Requirements
- R1: While reset is asserted and right after it, the outputs are `rasN`=all ones, `casN`=all ones, `weN`=1, `initDone`=0, `refReq`=0 and `overflow`=0.
- R2: After reset is released, the strobes stay inactive for `POWERUP_US*CLK_MHZ` clocks. At the defaults this is 200 µs, or 20000 clocks. The first CAS fall is seen on the clock after that.
- R3: After the pause, exactly 8 refresh cycles run without any grant. `initDone` rises when the 8th one completes and then stays high until reset. `refReq` stays low while `initDone` is low.
- R4: In every refresh cycle all CAS lines fall exactly one clock (≥5 ns) before RAS falls. They stay low for the whole RAS-low time and rise on the same clock as RAS.
- R5: Both RAS lines always switch together, all four CAS lines always switch together, and `weN` is 1 at all times.
- R6: RAS low time is max(tRAS, tRC−tRP) rounded up to clocks, and RAS precharge is at least tRP. For the 50 ns grade at 100 MHz this is 6 clocks low and at least 3 clocks high. For the 60 ns grade it is 7 clocks low and at least 4 clocks high.
- R7: The refresh interval is floor(`CLK_MHZ*WINDOW_US/ROW_COUNT`) clocks. This is 1562 at the defaults and 400 with the bench's parameters. With `refGrant` held high, successive RAS falls are exactly one interval apart.
- R8: After start-up, `refReq` is high whenever one or more refreshes are owed. No refresh cycle starts while `refGrant` is low, and a cycle starts once `refGrant` is high.
- R9: If the grant is withheld for N intervals, granting then produces exactly min(N, 8) refresh cycles before `refReq` drops.
- R10: A request that arrives while 8 are already owed sets `overflow`. The flag stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| refGrant | input | 1 | Sequencer releases the strobes to refresh |
| refReq | output | 1 | One or more refresh cycles are owed |
| initDone | output | 1 | Power-up pause and warm-up are finished |
| overflow | output | 1 | Sticky flag: a request was lost because the owed count was full |
| rasN | output | RANKS | Row strobes, active low, one per rank |
| casN | output | LANES | Column strobes, active low, one per byte lane |
| weN | output | 1 | Write enable, active low, held high |

## Verification
The checker watches, on every clock, the relationships inside one refresh cycle. These are: CAS leading RAS and staying low under it, the minimum RAS precharge, ranks and lanes moving together, and WE staying high. It also checks that `initDone` and `overflow` never clear, and that a cycle after start-up begins only after a grant and a request.

The bench scenarios cover what needs counting over long spans. These are the exact length of the power-up pause, the warm-up count, the refresh interval, the exact RAS low width, and the number of cycles drained after the grant was withheld for 1, 3, 8 and 9 intervals, including the capped case that sets the overflow flag.

// File: rtl/cbr_refresh_pkg.sv
package cbr_refresh_pkg;

  typedef enum logic [2:0] {
    PH_PWRUP,
    PH_IDLE,
    PH_LEAD,
    PH_RASLO,
    PH_PRECH
  } refPhase_e;

  // control -> datapath strobes
  typedef struct packed {
    logic casDrive;     // column strobes active
    logic rasDrive;     // row strobes active
    logic cycleDone;    // a granted refresh cycle finished this clock
    logic periodicRun;  // interval timer may run
  } refStrobe_t;

  function automatic int nsToCycles(input int ns, input int mhz);
    int c;
    c = (ns * mhz + 999) / 1000;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int maxOf3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/refresh_ctrl.sv
module refresh_ctrl
  import cbr_refresh_pkg::*;
#(
  parameter int PWR_CYC  = 20000,
  parameter int LEAD_CYC = 1,
  parameter int LOW_CYC  = 6,
  parameter int RP_CYC   = 3,
  parameter int WARMUP   = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       refGrant,
  input  logic       pendingAny,
  output refStrobe_t strobe,
  output logic       initDone
);

  localparam int PW_W  = $clog2(PWR_CYC + 1);
  localparam int PH_MX = maxOf3(LEAD_CYC, LOW_CYC, RP_CYC);
  localparam int PH_W  = $clog2(PH_MX + 1);
  localparam int WM_W  = $clog2(WARMUP + 1);

  refPhase_e        phase;
  logic [PW_W-1:0]  pwrCnt;
  logic [PH_W-1:0]  phaseCnt;
  logic [WM_W-1:0]  warmCnt;
  logic             phaseLast;

  always_comb begin
    unique case (phase)
      PH_LEAD:  phaseLast = (phaseCnt == PH_W'(LEAD_CYC - 1));
      PH_RASLO: phaseLast = (phaseCnt == PH_W'(LOW_CYC - 1));
      PH_PRECH: phaseLast = (phaseCnt == PH_W'(RP_CYC - 1));
      default:  phaseLast = 1'b0;
    endcase
  end

  always_comb begin
    strobe.casDrive    = (phase == PH_LEAD) || (phase == PH_RASLO);
    strobe.rasDrive    = (phase == PH_RASLO);
    strobe.cycleDone   = (phase == PH_PRECH) && phaseLast && initDone;
    strobe.periodicRun = initDone;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase    <= PH_PWRUP;
      pwrCnt   <= '0;
      phaseCnt <= '0;
      warmCnt  <= '0;
      initDone <= 1'b0;
    end else begin
      unique case (phase)
        PH_PWRUP: begin
          if (pwrCnt == PW_W'(PWR_CYC - 1)) begin
            phase    <= PH_LEAD;
            phaseCnt <= '0;
          end else begin
            pwrCnt <= pwrCnt + 1'b1;
          end
        end
        PH_IDLE: begin
          if (pendingAny && refGrant) begin
            phase    <= PH_LEAD;
            phaseCnt <= '0;
          end
        end
        PH_LEAD: begin
          if (phaseLast) begin
            phase    <= PH_RASLO;
            phaseCnt <= '0;
          end else begin
            phaseCnt <= phaseCnt + 1'b1;
          end
        end
        PH_RASLO: begin
          if (phaseLast) begin
            phase    <= PH_PRECH;
            phaseCnt <= '0;
          end else begin
            phaseCnt <= phaseCnt + 1'b1;
          end
        end
        PH_PRECH: begin
          if (phaseLast) begin
            phaseCnt <= '0;
            if (!initDone) begin
              if (warmCnt == WM_W'(WARMUP - 1)) begin
                initDone <= 1'b1;
                phase    <= PH_IDLE;
              end else begin
                warmCnt <= warmCnt + 1'b1;
                phase   <= PH_LEAD;
              end
            end else begin
              phase <= PH_IDLE;
            end
          end else begin
            phaseCnt <= phaseCnt + 1'b1;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/refresh_datapath.sv
module refresh_datapath
  import cbr_refresh_pkg::*;
#(
  parameter int RANKS       = 2,
  parameter int LANES       = 4,
  parameter int INT_CYC     = 1562,
  parameter int PENDING_MAX = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  refStrobe_t       strobe,
  output logic             pendingAny,
  output logic             overflow,
  output logic [RANKS-1:0] rasN,
  output logic [LANES-1:0] casN,
  output logic             weN
);

  localparam int IT_W = $clog2(INT_CYC);
  localparam int PD_W = $clog2(PENDING_MAX + 1);

  logic [IT_W-1:0] intervalCnt;
  logic [PD_W-1:0] pendingCnt;
  logic            tick;

  assign tick       = strobe.periodicRun && (intervalCnt == IT_W'(INT_CYC - 1));
  assign pendingAny = (pendingCnt != '0);
  assign weN        = 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN || !strobe.periodicRun) begin
      intervalCnt <= '0;
    end else if (tick) begin
      intervalCnt <= '0;
    end else begin
      intervalCnt <= intervalCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendingCnt <= '0;
      overflow   <= 1'b0;
    end else begin
      unique case ({tick, strobe.cycleDone})
        2'b10: begin
          if (pendingCnt == PD_W'(PENDING_MAX)) overflow <= 1'b1;
          else pendingCnt <= pendingCnt + 1'b1;
        end
        2'b01:   pendingCnt <= pendingCnt - 1'b1;
        default: pendingCnt <= pendingCnt;
      endcase
    end
  end

  for (genvar r = 0; r < RANKS; r++) begin : g_rank
    always_ff @(posedge clk) begin
      if (!rstN) rasN[r] <= 1'b1;
      else       rasN[r] <= !strobe.rasDrive;
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rstN) casN[l] <= 1'b1;
      else       casN[l] <= !strobe.casDrive;
    end
  end

endmodule

// File: rtl/cbr_refresh_sched.sv
module cbr_refresh_sched
  import cbr_refresh_pkg::*;
#(
  parameter int CLK_MHZ     = 100,
  parameter int SPEED_NS    = 50,
  parameter int POWERUP_US  = 200,
  parameter int WINDOW_US   = 64000,
  parameter int ROW_COUNT   = 4096,
  parameter int WARMUP      = 8,
  parameter int PENDING_MAX = 8,
  parameter int RANKS       = 2,
  parameter int LANES       = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             refGrant,
  output logic             refReq,
  output logic             initDone,
  output logic             overflow,
  output logic [RANKS-1:0] rasN,
  output logic [LANES-1:0] casN,
  output logic             weN
);

  localparam int T_RAS    = (SPEED_NS == 60) ? 60 : 50;
  localparam int T_RP     = (SPEED_NS == 60) ? 40 : 30;
  localparam int T_RC     = (SPEED_NS == 60) ? 110 : 90;
  localparam int T_CSR    = 5;
  localparam int T_CHR    = 10;
  localparam int LEAD_CYC = nsToCycles(T_CSR, CLK_MHZ);
  localparam int RP_CYC   = nsToCycles(T_RP, CLK_MHZ);
  localparam int LOW_CYC  = maxOf3(nsToCycles(T_RAS, CLK_MHZ),
                                   nsToCycles(T_RC, CLK_MHZ) - RP_CYC,
                                   nsToCycles(T_CHR, CLK_MHZ));
  localparam int PWR_CYC  = POWERUP_US * CLK_MHZ;
  localparam int INT_CYC  = (CLK_MHZ * WINDOW_US) / ROW_COUNT;

  refStrobe_t strobe;
  logic       pendingAny;

  refresh_ctrl #(
    .PWR_CYC (PWR_CYC),
    .LEAD_CYC(LEAD_CYC),
    .LOW_CYC (LOW_CYC),
    .RP_CYC  (RP_CYC),
    .WARMUP  (WARMUP)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .refGrant  (refGrant),
    .pendingAny(pendingAny),
    .strobe    (strobe),
    .initDone  (initDone)
  );

  refresh_datapath #(
    .RANKS      (RANKS),
    .LANES      (LANES),
    .INT_CYC    (INT_CYC),
    .PENDING_MAX(PENDING_MAX)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .pendingAny(pendingAny),
    .overflow  (overflow),
    .rasN      (rasN),
    .casN      (casN),
    .weN       (weN)
  );

  assign refReq = pendingAny;

endmodule

// File: rtl/cbr_refresh_sched_chk.sv
module cbr_refresh_sched_chk #(
  parameter int RANKS = 2,
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             refGrant,
  input logic             refReq,
  input logic             initDone,
  input logic             overflow,
  input logic [RANKS-1:0] rasN,
  input logic [LANES-1:0] casN,
  input logic             weN
);

  // R4
  cas_lead_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rasN[0]) |-> (casN == '0) && ($past(casN) == '0));

  // R4
  cas_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rasN[0] == 1'b0) |-> (casN == '0));

  // R5
  lanes_together_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((rasN == '0) || (rasN == '1)) && ((casN == '0) || (casN == '1)) && weN);

  // R6
  precharge_min_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rasN[0]) |-> $past(rasN[0], 1) && $past(rasN[0], 2) && $past(rasN[0], 3));

  // R3
  req_gated_chk: assert property (@(posedge clk) disable iff (!rstN)
    !initDone |-> !refReq);

  // R3
  init_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    initDone |=> initDone);

  // R10
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    overflow |=> overflow);

  // R8
  grant_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(casN[0]) && initDone) |-> ($past(refGrant) && $past(refReq)));

endmodule

bind cbr_refresh_sched cbr_refresh_sched_chk #(.RANKS(RANKS), .LANES(LANES)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .refGrant(refGrant),
  .refReq  (refReq),
  .initDone(initDone),
  .overflow(overflow),
  .rasN    (rasN),
  .casN    (casN),
  .weN     (weN)
);

// File: tb/cbr_refresh_sched_test.sv
module cbr_refresh_sched_test;

  localparam int CLK_MHZ  = 100;
  localparam int PWR_US   = 2;
  localparam int WIN_US   = 256;
  localparam int ROWS     = 64;
  localparam int PWR_CYC  = PWR_US * CLK_MHZ;       // 200
  localparam int INT_CYC  = CLK_MHZ * WIN_US / ROWS; // 400
  localparam int LEAD_EXP = 1;
  localparam int LOW_EXP  = 6;
  localparam int RP_MIN   = 3;

  // vector table: intervals withheld, expected drained cycles, expected overflow
  localparam int VEC_HELD  [4] = '{1, 3, 8, 9};
  localparam int VEC_BURST [4] = '{1, 3, 8, 8};
  localparam int VEC_OVF   [4] = '{0, 0, 0, 1};

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       refGrant = 1'b0;
  logic       refReq, initDone, overflow, weN;
  logic [1:0] rasN;
  logic [3:0] casN;

  int  vectors = 0;
  int  miscompares = 0;
  bit  finished = 1'b0;

  int  rasFalls = 0;
  int  cycleNo = 0;
  int  lastFallCycle = 0;
  int  casLowRun = 0;
  int  rasLowRun = 0;
  int  rasHighRun = 0;
  logic [1:0] prevRas = 2'b11;

  always #2 clk = ~clk;

  cbr_refresh_sched #(
    .CLK_MHZ   (CLK_MHZ),
    .SPEED_NS  (50),
    .POWERUP_US(PWR_US),
    .WINDOW_US (WIN_US),
    .ROW_COUNT (ROWS)
  ) uut (
    .clk     (clk),
    .rstN    (rstN),
    .refGrant(refGrant),
    .refReq  (refReq),
    .initDone(initDone),
    .overflow(overflow),
    .rasN    (rasN),
    .casN    (casN),
    .weN     (weN)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // strobe monitor
  always @(negedge clk) begin
    cycleNo++;
    if (!rstN) begin
      rasFalls   = 0;
      casLowRun  = 0;
      rasLowRun  = 0;
      rasHighRun = 1000;
      prevRas    = 2'b11;
    end else begin
      // R5 lines move together, WE held high
      check((rasN == 2'b00 || rasN == 2'b11) && (casN == 4'h0 || casN == 4'hF) && weN,
            "R5", {rasN, casN, weN}, 0);
      // R3 no request before start-up ends
      if (!initDone) check(!refReq, "R3", refReq, 0);
      if (prevRas == 2'b11 && rasN == 2'b00) begin
        check(casLowRun == LEAD_EXP, "R4", casLowRun, LEAD_EXP);
        check(rasHighRun >= RP_MIN, "R6", rasHighRun, RP_MIN);
        rasFalls++;
        lastFallCycle = cycleNo;
      end
      if (prevRas == 2'b00 && rasN == 2'b11) begin
        check(rasLowRun == LOW_EXP, "R6", rasLowRun, LOW_EXP);
        check(casN == 4'hF, "R4", casN, 4'hF);
      end
      if (rasN == 2'b00) check(casN == 4'h0, "R4", casN, 0);
      casLowRun  = (casN == 4'h0) ? casLowRun + 1 : 0;
      rasLowRun  = (rasN == 2'b00) ? rasLowRun + 1 : 0;
      rasHighRun = (rasN == 2'b11) ? rasHighRun + 1 : 0;
      prevRas    = rasN;
    end
  end

  task automatic runVector(input int idx);
    int startFalls;
    refGrant = 1'b0;
    while (!refReq) @(negedge clk);
    startFalls = rasFalls;
    repeat ((VEC_HELD[idx] - 1) * INT_CYC + INT_CYC / 2) @(negedge clk);
    check(rasFalls == startFalls, "R8", rasFalls - startFalls, 0);
    check(refReq == 1'b1, "R8", refReq, 1);
    refGrant   = 1'b1;
    startFalls = rasFalls;
    while (refReq) @(negedge clk);
    repeat (3) @(negedge clk);
    refGrant = 1'b0;
    check(rasFalls - startFalls == VEC_BURST[idx], "R9", rasFalls - startFalls, VEC_BURST[idx]);
    check(overflow == VEC_OVF[idx][0], "R10", overflow, VEC_OVF[idx]);
  endtask

  initial begin
    int quiet;
    int f0;
    int c1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(rasN == 2'b11 && casN == 4'hF && weN, "R1", {rasN, casN, weN}, 7'h7F);
    check(!initDone && !refReq && !overflow, "R1", {initDone, refReq, overflow}, 0);
    rstN = 1'b1;
    // R2 power-up pause length
    quiet = 0;
    while (casN == 4'hF) begin
      @(negedge clk);
      quiet++;
    end
    check(quiet == PWR_CYC + 1, "R2", quiet, PWR_CYC + 1);
    check(rasFalls == 0, "R2", rasFalls, 0);
    // R3 warm-up without grant
    while (!initDone) @(negedge clk);
    check(rasFalls == 8, "R3", rasFalls, 8);
    check(!refReq, "R3", refReq, 0);
    // R7 periodic spacing with grant held
    refGrant = 1'b1;
    f0 = rasFalls;
    wait (rasFalls > f0);
    c1 = lastFallCycle;
    for (int k = 0; k < 3; k++) begin
      f0 = rasFalls;
      wait (rasFalls > f0);
      check(lastFallCycle - c1 == INT_CYC, "R7", lastFallCycle - c1, INT_CYC);
      c1 = lastFallCycle;
    end
    repeat (20) @(negedge clk);
    check(!refReq, "R8", refReq, 0);
    refGrant = 1'b0;
    // R9 / R10 deferral table
    for (int v = 0; v < 4; v++) runVector(v);
    // R10 sticky overflow
    repeat (INT_CYC) @(negedge clk);
    check(overflow == 1'b1, "R10", overflow, 1);
    // R3 initDone still held
    check(initDone == 1'b1, "R3", initDone, 1);
    // R1 reset clears everything
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    check(!overflow && !initDone && !refReq, "R1", {overflow, initDone, refReq}, 0);
    check(rasN == 2'b11 && casN == 4'hF, "R1", {rasN, casN}, 6'h3F);
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      vectors++;
      miscompares++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule